// File: doc/BRIEF.md
# Step-Based Multiply/Divide Arithmetic Unit

This unit is a 32-bit arithmetic block that completes one operation for each accepted request. It covers addition, subtraction, three bitwise logic functions, and placing or pulling a single byte within a word. It has no full multiplier or divider. Instead it offers two step primitives. A radix-4 Booth multiply step consumes two multiplier bits per request. A non-restoring divide step yields one quotient bit per request. Software builds a complete product from 16 multiply steps and a complete quotient from 32 divide steps. Between steps it keeps the accumulator or partial remainder, the multiplier or quotient word, and the one-bit Booth link in its own registers and feeds them back in.

One carry-lookahead adder, two bits wider than the word, serves addition, subtraction and both step operations. Only one of these can use it in a given request. Signed overflow on addition or subtraction raises a trap-request flag alongside the result.

Requests and results travel over valid/ready. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is held in a single output register. That register raises `out_valid` on the next cycle and stays frozen until a cycle with `out_ready` high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer with no result lost.

Top module: `step_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A request accepted at an edge shows its result with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and every output holds its value.
- R2: Code 0 returns a+b and code 1 returns a-b, both modulo 2^32. `out_ovf` is 1 exactly when the signed two's-complement result does not fit in 32 bits.
- R3: Codes 2, 3 and 4 return a AND b, a OR b and a XOR b.
- R4: Code 5 (byte extract) returns byte `in_bsel` of a, zero-extended. Selector 0 is bits 7:0 and selector 3 is bits 31:24.
- R5: Code 6 (byte insert) returns b with byte `in_bsel` replaced by a[7:0]. The other three bytes of b are unchanged.
- R6: Code 7 (Booth step) treats a as the accumulator, b as the multiplicand, aux as the multiplier word and link as the previously shifted-out bit. It adds k·b to sign-extended a, where k = -2·aux[1] + aux[0] + link. It then shifts the 66-bit pair {sum, aux} arithmetically right by two. `out_res` is the upper word, `out_aux` is the lower word and `out_link` is the old aux[1].
- R7: Starting from a=0, link=0 and aux=Y, sixteen chained Booth steps with multiplicand M leave {out_res, out_aux} equal to the signed 64-bit product M·Y.
- R8: Code 8 (divide step) treats a as the signed partial remainder, aux as the dividend/quotient word and b as the divisor. It forms 2·a + aux[31] and subtracts b when a ≥ 0, or adds b when a < 0. The new remainder goes to `out_res`. `out_aux` is aux shifted left by one, with bit 0 set to 1 exactly when the new remainder is non-negative.
- R9: Starting from a=0 and aux=N, with a divisor D in 1..2^31-1, thirty-two chained divide steps leave `out_aux` = N/D (unsigned). The remainder N mod D equals `out_res`, or `out_res`+D when `out_res` is negative.
- R10: `out_ovf` is 0 for every code other than 0 and 1. Every code other than 7 and 8 passes aux to `out_aux` unchanged and drives `out_link` to 0. Codes 9 to 15 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | Operand a / accumulator / partial remainder |
| in_b | input | 32 | Operand b / multiplicand / divisor |
| in_aux | input | 32 | Multiplier or dividend/quotient word |
| in_link | input | 1 | Booth bit shifted out by the previous step |
| in_bsel | input | 2 | Byte selector for extract and insert |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 32 | Main result |
| out_aux | output | 32 | Updated multiplier or quotient word |
| out_link | output | 1 | Updated Booth link bit |
| out_ovf | output | 1 | Signed-overflow trap request |

## Verification
The state is fed back by the caller, so a single wrong step corrupts every following step of a chain. A bad Booth digit or a wrong quotient bit therefore appears in the register right after that step, and it also shows as a wrong final product or quotient 16 or 32 steps later. Each step is compared against an arithmetic model at the cycle after acceptance, and so is each end-of-chain result. A broken adder carry chain or a bad byte lane shows directly in the next result for the operand patterns that exercise that lane or carry. A handshake fault shows as a result that changes or vanishes while the consumer is stalled.

// File: rtl/step_alu_pkg.sv
package step_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_BEXT  = 4'd5,
    OP_BINS  = 4'd6,
    OP_MSTEP = 4'd7,
    OP_DSTEP = 4'd8
  } op_e;
endpackage

// File: rtl/step_alu_cla.sv
module step_alu_cla #(
  parameter int W = 34,
  parameter int G = 2
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int NG = (W + G - 1) / G;
  localparam int PW = NG * G;

  logic [PW-1:0] xp, yp, p, g, c;
  logic [NG-1:0] grp_g, grp_p;
  logic [NG:0]   gc;

  always_comb begin
    xp = '0;
    yp = '0;
    xp[W-1:0] = x;
    yp[W-1:0] = y;
  end

  assign p = xp ^ yp;
  assign g = xp & yp;

  // carries between groups, from group generate/propagate
  always_comb begin
    gc[0] = cin;
    for (int k = 0; k < NG; k++)
      gc[k+1] = grp_g[k] | (grp_p[k] & gc[k]);
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [G-1:0] bp, bg;
    logic [G-1:0] cc;
    assign bp = p[k*G +: G];
    assign bg = g[k*G +: G];

    // group terms, flattened lookahead form
    always_comb begin
      logic acc, run;
      acc = bg[G-1];
      run = bp[G-1];
      for (int i = G - 2; i >= 0; i--) begin
        acc = acc | (run & bg[i]);
        run = run & bp[i];
      end
      grp_g[k] = acc;
      grp_p[k] = run;
    end

    // carry into each bit of the group from the group carry-in
    always_comb begin
      cc[0] = gc[k];
      for (int j = 1; j < G; j++) begin
        logic acc, run;
        acc = bg[j-1];
        run = bp[j-1];
        for (int i = j - 2; i >= 0; i--) begin
          acc = acc | (run & bg[i]);
          run = run & bp[i];
        end
        cc[j] = acc | (run & gc[k]);
      end
    end
    assign c[k*G +: G] = cc;
  end

  assign sum = p[W-1:0] ^ c[W-1:0];
endmodule

// File: rtl/step_alu_booth.sv
module step_alu_booth #(
  parameter int W = 32
) (
  input  logic [W-1:0] mcand,
  input  logic [1:0]   mplr_lo,
  input  logic         link,
  output logic [W+1:0] addend,
  output logic         neg
);
  localparam int AW = W + 2;

  logic [AW-1:0] one_m, two_m, mag;

  assign one_m = {{2{mcand[W-1]}}, mcand};
  assign two_m = {mcand[W-1], mcand, 1'b0};

  // recode {b1, b0, link} to a digit in -2..+2
  always_comb begin
    mag = '0;
    neg = 1'b0;
    unique case ({mplr_lo, link})
      3'b001, 3'b010: mag = one_m;
      3'b011:         mag = two_m;
      3'b100: begin   mag = two_m; neg = 1'b1; end
      3'b101, 3'b110: begin mag = one_m; neg = 1'b1; end
      default:        mag = '0;
    endcase
  end

  assign addend = neg ? ~mag : mag;
endmodule

// File: rtl/step_alu_div.sv
module step_alu_div #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] qreg,
  input  logic [W-1:0] divisor,
  input  logic [W:0]   sum,
  output logic [W+1:0] x_op,
  output logic [W+1:0] y_op,
  output logic         cin,
  output logic [W-1:0] new_rem,
  output logic [W-1:0] new_q
);
  logic sub;

  // non-negative remainder subtracts, negative remainder adds back
  assign sub  = ~rem[W-1];
  assign x_op = {rem[W-1], rem, qreg[W-1]};
  assign y_op = sub ? ~{{2{divisor[W-1]}}, divisor} : {{2{divisor[W-1]}}, divisor};
  assign cin  = sub;

  assign new_rem = sum[W-1:0];
  assign new_q   = {qreg[W-2:0], ~sum[W]};
endmodule

// File: rtl/step_alu_byte.sv
module step_alu_byte #(
  parameter int W = 32
) (
  input  logic [W-1:0]                 a,
  input  logic [W-1:0]                 b,
  input  logic [$clog2(W/8)-1:0]       sel,
  output logic [W-1:0]                 ext,
  output logic [W-1:0]                 ins
);
  localparam int NB = W / 8;

  logic [NB-1:0][7:0] lanes_a, lanes_b, lanes_ins;
  logic [NB-1:0]      hit;

  assign lanes_a = a;
  assign lanes_b = b;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign hit[i]       = (sel == i[$clog2(W/8)-1:0]);
    assign lanes_ins[i] = hit[i] ? a[7:0] : lanes_b[i];
  end

  always_comb begin
    ext = '0;
    for (int i = 0; i < NB; i++)
      if (hit[i]) ext[7:0] = lanes_a[i];
  end

  assign ins = lanes_ins;
endmodule

// File: rtl/step_alu.sv
module step_alu
  import step_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CLA_GROUP = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [3:0]                     in_op,
  input  logic [WIDTH-1:0]               in_a,
  input  logic [WIDTH-1:0]               in_b,
  input  logic [WIDTH-1:0]               in_aux,
  input  logic                           in_link,
  input  logic [$clog2(WIDTH/8)-1:0]     in_bsel,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [WIDTH-1:0]               out_res,
  output logic [WIDTH-1:0]               out_aux,
  output logic                           out_link,
  output logic                           out_ovf
);
  localparam int AW = WIDTH + 2;

  op_e op;
  assign op = op_e'(in_op);

  logic          accept;
  logic [AW-1:0] add_x, add_y, add_s;
  logic          add_c;

  logic [AW-1:0]    bth_addend;
  logic             bth_neg;
  logic [AW-1:0]    div_x, div_y;
  logic             div_c;
  logic [WIDTH-1:0] div_rem, div_q;
  logic [WIDTH-1:0] byte_ext, byte_ins;

  logic [WIDTH-1:0] nx_res, nx_aux;
  logic             nx_link, nx_ovf;

  step_alu_booth #(.W(WIDTH)) u_booth (
    .mcand(in_b), .mplr_lo(in_aux[1:0]), .link(in_link),
    .addend(bth_addend), .neg(bth_neg)
  );

  step_alu_div #(.W(WIDTH)) u_div (
    .rem(in_a), .qreg(in_aux), .divisor(in_b), .sum(add_s[WIDTH:0]),
    .x_op(div_x), .y_op(div_y), .cin(div_c),
    .new_rem(div_rem), .new_q(div_q)
  );

  step_alu_byte #(.W(WIDTH)) u_byte (
    .a(in_a), .b(in_b), .sel(in_bsel), .ext(byte_ext), .ins(byte_ins)
  );

  // one adder, steered to whichever operation owns it this request
  always_comb begin
    add_x = {{2{in_a[WIDTH-1]}}, in_a};
    add_y = {{2{in_b[WIDTH-1]}}, in_b};
    add_c = 1'b0;
    unique case (op)
      OP_SUB: begin
        add_y = ~{{2{in_b[WIDTH-1]}}, in_b};
        add_c = 1'b1;
      end
      OP_MSTEP: begin
        add_y = bth_addend;
        add_c = bth_neg;
      end
      OP_DSTEP: begin
        add_x = div_x;
        add_y = div_y;
        add_c = div_c;
      end
      default: ;
    endcase
  end

  step_alu_cla #(.W(AW), .G(CLA_GROUP)) u_cla (
    .x(add_x), .y(add_y), .cin(add_c), .sum(add_s)
  );

  always_comb begin
    nx_res  = '0;
    nx_aux  = in_aux;
    nx_link = 1'b0;
    nx_ovf  = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        nx_res = add_s[WIDTH-1:0];
        nx_ovf = add_s[WIDTH] ^ add_s[WIDTH-1];
      end
      OP_AND:  nx_res = in_a & in_b;
      OP_OR:   nx_res = in_a | in_b;
      OP_XOR:  nx_res = in_a ^ in_b;
      OP_BEXT: nx_res = byte_ext;
      OP_BINS: nx_res = byte_ins;
      OP_MSTEP: begin
        nx_res  = add_s[AW-1:2];
        nx_aux  = {add_s[1:0], in_aux[WIDTH-1:2]};
        nx_link = in_aux[1];
      end
      OP_DSTEP: begin
        nx_res = div_rem;
        nx_aux = div_q;
      end
      default: nx_res = '0;
    endcase
  end

  // single output register with valid/ready
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_aux   <= '0;
      out_link  <= 1'b0;
      out_ovf   <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_res   <= nx_res;
      out_aux   <= nx_aux;
      out_link  <= nx_link;
      out_ovf   <= nx_ovf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: a stalled result does not move
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_aux)
                                   && $stable(out_link) && $stable(out_ovf)));

  // R10: only add/subtract may raise the trap request
  a_r10_ovf_addsub_only: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op != 4'd0 && in_op != 4'd1) |=> !out_ovf);

  // R4: extracted byte lands zero-extended
  a_r4_bext_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == 4'd5) |=> (out_res[WIDTH-1:8] == '0));

  // R6: link carries the multiplier bit shifted out by this step
  a_r6_link_from_aux: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == 4'd7) |=> (out_link == $past(in_aux[1])));

  // R8: quotient bit mirrors the sign of the new remainder
  a_r8_qbit_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == 4'd8) |=> (out_aux[0] == !out_res[WIDTH-1]));

  // R1: result follows every accepted request
  a_r1_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/step_alu_bench.sv
module step_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_aux = '0;
  logic        in_link = 1'b0;
  logic [1:0]  in_bsel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res, out_aux;
  logic        out_link, out_ovf;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  step_alu u_step_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_aux(in_aux), .in_link(in_link),
    .in_bsel(in_bsel), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_aux(out_aux), .out_link(out_link), .out_ovf(out_ovf)
  );

  function automatic logic [31:0] val(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'h0000_0002;  3: return 32'h0000_0007;
      4: return 32'h7fff_ffff;  5: return 32'h8000_0000;
      6: return 32'hffff_ffff;  7: return 32'h1234_5678;
      8: return 32'hdead_beef;  9: return 32'h0001_0000;
      10: return 32'h8000_0001; default: return 32'h55aa_33cc;
    endcase
  endfunction

  function automatic logic [31:0] dvs(input int i);
    case (i)
      0: return 32'd1;  1: return 32'd2;  2: return 32'd3;  3: return 32'd7;
      4: return 32'd10; 5: return 32'd255; 6: return 32'd65537;
      default: return 32'h7fff_ffff;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] aux, input logic lk, input logic [1:0] sel);
    @(negedge clk);
    in_op = op; in_a = a; in_b = b; in_aux = aux; in_link = lk; in_bsel = sel;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Booth step model: returns {hi, lo, link}
  function automatic logic [64:0] bstep(input logic [31:0] acc, input logic [31:0] m,
                                        input logic [31:0] lo, input logic lk);
    longint k, s;
    k = 0 - 2 * longint'(lo[1]) + longint'(lo[0]) + longint'(lk);
    s = longint'($signed(acc)) + k * longint'($signed(m));
    return {s[33:2], s[1:0], lo[31:2], lo[1]};
  endfunction

  // divide step model: returns {rem, q}
  function automatic logic [63:0] dstep(input logic [31:0] rem, input logic [31:0] lo,
                                        input logic [31:0] d);
    longint r, sh, nr;
    r  = longint'($signed(rem));
    sh = 2 * r + longint'(lo[31]);
    nr = (r >= 0) ? sh - longint'(d) : sh + longint'(d);
    return {nr[31:0], lo[30:0], (nr >= 0)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] a, b, acc, lo, d, exp_r;
    logic        lk;
    longint      s, p;

    repeat (3) @(negedge clk);
    chk("R1 reset valid/ready", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;

    // R2 add/subtract with overflow
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        a = val(i); b = val(j);
        issue(4'd0, a, b, 32'h0, 1'b0, 2'd0);
        s = longint'($signed(a)) + longint'($signed(b));
        chk("R2 add", {31'd0, out_ovf, out_res},
            {31'd0, (s > 64'sd2147483647 || s < -64'sd2147483648), a + b});
        issue(4'd1, a, b, 32'h0, 1'b0, 2'd0);
        s = longint'($signed(a)) - longint'($signed(b));
        chk("R2 sub", {31'd0, out_ovf, out_res},
            {31'd0, (s > 64'sd2147483647 || s < -64'sd2147483648), a - b});
      end

    // R3 logic, R10 aux passthrough and flags
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++) begin
        a = val(i); b = val(j);
        issue(4'd2, a, b, b, 1'b1, 2'd0);
        chk("R3 and", {32'd0, out_res}, {32'd0, a & b});
        chk("R10 passthrough", {out_ovf, out_link, out_aux}, {2'b00, b});
        issue(4'd3, a, b, a, 1'b0, 2'd0);
        chk("R3 or", {32'd0, out_res}, {32'd0, a | b});
        issue(4'd4, a, b, a, 1'b0, 2'd0);
        chk("R3 xor", {32'd0, out_res}, {32'd0, a ^ b});
      end

    // R4 extract, R5 insert over every selector
    for (int i = 0; i < 12; i++)
      for (int sel = 0; sel < 4; sel++) begin
        a = val(i); b = val(11 - i);
        issue(4'd5, a, b, 32'h0, 1'b0, sel[1:0]);
        chk("R4 extract", {32'd0, out_res}, {32'd0, 24'd0, a[sel*8 +: 8]});
        issue(4'd6, a, b, 32'h0, 1'b0, sel[1:0]);
        exp_r = b; exp_r[sel*8 +: 8] = a[7:0];
        chk("R5 insert", {32'd0, out_res}, {32'd0, exp_r});
      end

    // R10 undefined codes
    for (int c = 9; c < 16; c++) begin
      issue(c[3:0], val(7), val(8), val(11), 1'b1, 2'd1);
      chk("R10 undefined", {out_ovf, out_link, out_res, out_aux}, {2'b00, 32'd0, val(11)});
    end

    // R6 per step, R7 full signed product
    for (int i = 0; i < 8; i++)
      for (int j = 4; j < 12; j++) begin
        b = val(i); acc = '0; lo = val(j); lk = 1'b0;
        for (int st = 0; st < 16; st++) begin
          logic [64:0] e;
          e = bstep(acc, b, lo, lk);
          issue(4'd7, acc, b, lo, lk, 2'd0);
          chk("R6 booth step", {out_res, out_aux}, e[64:1]);
          chk("R6 link", {63'd0, out_link}, {63'd0, e[0]});
          acc = out_res; lo = out_aux; lk = out_link;
        end
        p = longint'($signed(b)) * longint'($signed(val(j)));
        chk("R7 product", {acc, lo}, p);
      end

    // R8 per step, R9 full quotient and remainder
    for (int i = 0; i < 12; i++)
      for (int k = 0; k < 8; k++) begin
        d = dvs(k); acc = '0; lo = val(i);
        for (int st = 0; st < 32; st++) begin
          issue(4'd8, acc, d, lo, 1'b0, 2'd0);
          chk("R8 divide step", {out_res, out_aux}, dstep(acc, lo, d));
          acc = out_res; lo = out_aux;
        end
        exp_r = acc[31] ? acc + d : acc;
        chk("R9 quotient", {32'd0, lo}, {32'd0, val(i) / d});
        chk("R9 remainder", {32'd0, exp_r}, {32'd0, val(i) % d});
      end

    // R1 back-pressure: hold first result, then accept the waiting one
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd0; in_a = 32'd5; in_b = 32'd6; in_aux = '0; in_link = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'd100; in_b = 32'd1;
    chk("R1 valid after accept", {63'd0, out_valid}, 64'd1);
    chk("R1 ready low when full", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R1 held result", {31'd0, out_valid, out_res}, {31'd0, 1'b1, 32'd11});
    chk("R1 ready still low", {63'd0, in_ready}, 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 next result", {31'd0, out_valid, out_res}, {31'd0, 1'b1, 32'd101});
    @(negedge clk);
    chk("R1 drained", {62'd0, out_valid, in_ready}, 64'd1);

    summary();
  end
endmodule